// File: doc/BRIEF.md
# Reset Cause Controller

This block merges six reset requests into a single chip reset and keeps a record of which of them caused each reset. The requests are a power-on detect, a brownout detect, an external reset pin, a watchdog timeout, a software reset request and a serial-line break detect. Each request has its own enable or disable input, so that system configuration can decide which sources may reset the chip. Only a request that passes its gate is called qualified. The chip reset is held for a minimum number of cycles after the last qualified request.

The power-on detect drives the block's own asynchronous active-low reset, `por_n`. An internal two-stage synchronizer releases that reset on a clock edge. The pin, break and brownout inputs are asynchronous and pass through a two-stage synchronizer. The watchdog timeout and the software request are already synchronous to `clk`.

Software sees a status byte of sticky cause flags. It clears a flag by writing 0 to that bit. A flag set by one reset survives the resets that follow, so a boot routine can see every cause since the last time it cleared the byte.

Top module: `rst_cause_ctrl`

## Requirements
- R1: Status byte layout: bit 0 external pin, bit 1 software, bit 2 watchdog, bit 3 break, bit 4 power-on, bit 5 brownout. Bits 7:6 always read as 0.
- R2: While `por_n` is low, the status reads 0x30 and `chip_rst` is 1. Power-on sets the power-on and brownout flags and clears all other flags.
- R3: If `ext_rst_in` is still high (with `ext_rst_en` = 1) when power-on ends, bit 0 becomes set. It shows on the fifth rising edge after `por_n` rises: two edges release the internal reset and two more synchronize the pin.
- R4: A qualified non-power-on request sets its own flag and leaves every flag that is already set unchanged.
- R5: A write clears exactly the flag bits written as 0. Writing 1 to a bit has no effect, and writes to bits 7:6 are ignored.
- R6: When a write of 0 and a new set event hit the same flag in the same cycle, the flag ends up set.
- R7: The external pin request is gated by `ext_rst_en`. When it is 0, the pin neither resets the chip nor sets bit 0.
- R8: The watchdog timeout is gated by `wdt_rst_en`. When it is 0, the timeout neither resets the chip nor sets bit 2.
- R9: The break detect is gated by `brk_rst_en`. When it is 0, a break neither resets the chip nor sets bit 3.
- R10: When `bod_rst_dis` is 1, a brownout neither resets the chip nor sets bit 5.
- R11: `chip_rst` rises on the clock edge that samples a qualified request. It stays high for exactly STRETCH (default 8) cycles after the last edge that sampled a request.
- R12: A synchronous source (watchdog, software) acts on the edge that samples it. An asynchronous source (pin, break, brownout) acts on the third edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on detect, active low, asynchronous |
| ext_rst_in | input | 1 | External reset pin request, active high, asynchronous |
| ext_rst_en | input | 1 | Allows the pin request through |
| wdt_tmo | input | 1 | Watchdog timeout, synchronous |
| wdt_rst_en | input | 1 | Allows the watchdog request through |
| sw_rst_req | input | 1 | Software reset request, synchronous |
| brk_det | input | 1 | Serial-line break detect, asynchronous |
| brk_rst_en | input | 1 | Allows a break to reset the chip |
| bod_det | input | 1 | Brownout detect, asynchronous |
| bod_rst_dis | input | 1 | Blocks the brownout reset path |
| reg_wr | input | 1 | Status write strobe |
| reg_wdata | input | 8 | Status write data (0 clears a bit) |
| reg_rdata | output | 8 | Status byte, always readable |
| chip_rst | output | 1 | Stretched chip reset, active high |

## Verification
Synchronous sources are due one edge after they are driven. Asynchronous sources are due on the third edge: two synchronizer stages, then the flag or counter register. The power-on pin case adds two more edges for the release of the internal reset. Write effects are due on the edge that samples the strobe. The bench drives and samples only on falling edges and counts rising edges exactly. It checks the asynchronous case just before and just after its due edge, and it counts the length of the reset pulse one sample at a time. Every table vector is sampled a fixed four edges after its stimulus, when both the flag and `chip_rst` must already show the result.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  localparam int NSRC   = 6;
  localparam int STAT_W = 8;

  localparam int IDX_EXT = 0;
  localparam int IDX_SW  = 1;
  localparam int IDX_WDT = 2;
  localparam int IDX_BRK = 3;
  localparam int IDX_POF = 4;
  localparam int IDX_BOF = 5;

  typedef logic [NSRC-1:0] src_vec_t;

  // Flag value left by a power-on: power-on and brownout set, all others clear.
  localparam src_vec_t FLAG_POR_VAL = src_vec_t'((1 << IDX_POF) | (1 << IDX_BOF));
endpackage

// File: rtl/rcc_sync.sv
module rcc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  if (STAGES < 2) begin : g_bad
    initial $error("rcc_sync needs at least two stages");
  end

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/rcc_flags.sv
module rcc_flags
  import rcc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t set,
  input  logic     wr,
  input  src_vec_t wdata,
  output src_vec_t flags
);
  src_vec_t flag_q;
  src_vec_t flag_d;
  src_vec_t clr;
  logic     flag_en;

  assign clr     = wr ? ~wdata : '0;
  assign flag_en = wr | (|set);

  always_comb begin
    flag_d = (flag_q & ~clr) | set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= FLAG_POR_VAL;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flags = flag_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_chk
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> flag_q[i]); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[i] && !(wr && !wdata[i])) |=> flag_q[i]); // R5
    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_q[i] && !set[i]) |=> !flag_q[i]); // R4
  end
endmodule

// File: rtl/rcc_stretch.sv
module rcc_stretch #(
  parameter int STRETCH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_any,
  output logic rst_out
);
  localparam int CW = $clog2(STRETCH + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign cnt_en = req_any | (cnt_q != '0);

  always_comb begin
    if (req_any) cnt_d = CW'(STRETCH);
    else         cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CW'(STRETCH);
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign rst_out = (cnt_q != '0);

  AST_REQ_RAISES_RST: assert property (@(posedge clk) disable iff (!rst_n)
    req_any |=> rst_out); // R11
  AST_FALL_ONLY_WHEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_out) |-> $past(!req_any)); // R11
endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
  import rcc_pkg::*;
#(
  parameter int STRETCH     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              ext_rst_in,
  input  logic              ext_rst_en,
  input  logic              wdt_tmo,
  input  logic              wdt_rst_en,
  input  logic              sw_rst_req,
  input  logic              brk_det,
  input  logic              brk_rst_en,
  input  logic              bod_det,
  input  logic              bod_rst_dis,
  input  logic              reg_wr,
  input  logic [STAT_W-1:0] reg_wdata,
  output logic [STAT_W-1:0] reg_rdata,
  output logic              chip_rst
);
  localparam int NASYNC = 3;

  logic              rst_n;
  logic [0:0]        rsync_q;
  logic [NASYNC-1:0] async_raw;
  logic [NASYNC-1:0] async_s;
  src_vec_t          req;
  src_vec_t          flag_q;
  logic              unused_wbits;

  // Power-on reset: asserted asynchronously, released on a clock edge.
  rcc_sync #(.W(1), .STAGES(SYNC_STAGES)) u_rst_sync (
    .clk   (clk),
    .rst_n (por_n),
    .d     (1'b1),
    .q     (rsync_q)
  );
  assign rst_n = rsync_q[0];

  assign async_raw = {bod_det, brk_det, ext_rst_in};

  rcc_sync #(.W(NASYNC), .STAGES(SYNC_STAGES)) u_in_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (async_raw),
    .q     (async_s)
  );

  // Source qualification.
  always_comb begin
    req          = '0;
    req[IDX_EXT] = async_s[0] & ext_rst_en;
    req[IDX_SW]  = sw_rst_req;
    req[IDX_WDT] = wdt_tmo & wdt_rst_en;
    req[IDX_BRK] = async_s[1] & brk_rst_en;
    req[IDX_BOF] = async_s[2] & ~bod_rst_dis;
  end

  rcc_flags u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (req),
    .wr    (reg_wr),
    .wdata (reg_wdata[NSRC-1:0]),
    .flags (flag_q)
  );

  rcc_stretch #(.STRETCH(STRETCH)) u_stretch (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_any (|req),
    .rst_out (chip_rst)
  );

  assign unused_wbits = ^reg_wdata[STAT_W-1:NSRC];
  assign reg_rdata    = {{(STAT_W-NSRC){1'b0}}, flag_q};

  AST_POF_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_q[IDX_POF] |=> !flag_q[IDX_POF]); // R2
  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (reg_rdata[STAT_W-1:NSRC] == '0)); // R1
endmodule

// File: tb/tb_rst_cause_ctrl.sv
module tb_rst_cause_ctrl;
  logic       clk = 1'b0;
  logic       por_n, ext_rst_in, ext_rst_en, wdt_tmo, wdt_rst_en, sw_rst_req;
  logic       brk_det, brk_rst_en, bod_det, bod_rst_dis, reg_wr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       chip_rst;

  int  total = 0;
  int  bad = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  rst_cause_ctrl dut (
    .clk(clk), .por_n(por_n), .ext_rst_in(ext_rst_in), .ext_rst_en(ext_rst_en),
    .wdt_tmo(wdt_tmo), .wdt_rst_en(wdt_rst_en), .sw_rst_req(sw_rst_req),
    .brk_det(brk_det), .brk_rst_en(brk_rst_en), .bod_det(bod_det),
    .bod_rst_dis(bod_rst_dis), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .chip_rst(chip_rst)
  );

  // Vector: [23] rst due, [21:16] flags due, [11:8] {brk_en,wdt_en,ext_en,bod_dis},
  // [5:0] stimulus on flag positions (0 pin, 1 sw, 2 wdt, 3 brk, 5 bod).
  localparam logic [23:0] VEC [9] = '{
    24'h810E01, // R7 pin enabled
    24'h000C01, // R7 pin disabled
    24'h840E04, // R8 watchdog enabled
    24'h000A04, // R8 watchdog disabled
    24'h820002, // R4 software
    24'h880E08, // R9 break enabled
    24'h000608, // R9 break disabled
    24'hA00E20, // R10 brownout allowed
    24'h000F20  // R10 brownout blocked
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_stat(input logic [7:0] v);
    reg_wr = 1'b1; reg_wdata = v;
    step(1);
    reg_wr = 1'b0; reg_wdata = 8'h00;
  endtask

  initial begin
    por_n = 1'b0; ext_rst_in = 1'b1; ext_rst_en = 1'b1;
    wdt_tmo = 1'b0; wdt_rst_en = 1'b0; sw_rst_req = 1'b0;
    brk_det = 1'b0; brk_rst_en = 1'b0; bod_det = 1'b0; bod_rst_dis = 1'b0;
    reg_wr = 1'b0; reg_wdata = 8'h00;

    // R2 reset state
    step(3);
    check("R2 status in power-on", reg_rdata, 8'h30);
    check("R2 chip_rst in power-on", {7'd0, chip_rst}, 8'h01);

    // R3 pin still held when power-on ends
    por_n = 1'b1;
    step(4);
    check("R3 pin flag not yet", reg_rdata, 8'h30);
    step(1);
    check("R3 pin flag after power-on", reg_rdata, 8'h31);
    ext_rst_in = 1'b0;
    step(12);
    check("R11 chip_rst released", {7'd0, chip_rst}, 8'h00);

    // R11 stretch length and R12 synchronous latency
    wr_stat(8'h00);
    begin
      int hi = 0;
      sw_rst_req = 1'b1;
      step(1);
      check("R12 sw flag on first edge", reg_rdata, 8'h02);
      sw_rst_req = 1'b0;
      if (chip_rst) hi++;
      for (int k = 0; k < 11; k++) begin
        step(1);
        if (chip_rst) hi++;
      end
      check("R11 stretch cycles", 8'(hi), 8'd8);
    end

    // Table walk: R4 R7 R8 R9 R10
    for (int v = 0; v < 9; v++) begin
      logic [23:0] e;
      e = VEC[v];
      brk_rst_en = e[11]; wdt_rst_en = e[10]; ext_rst_en = e[9]; bod_rst_dis = e[8];
      wr_stat(8'h00);
      ext_rst_in = e[0]; sw_rst_req = e[1]; wdt_tmo = e[2]; brk_det = e[3]; bod_det = e[5];
      step(1);
      ext_rst_in = 1'b0; sw_rst_req = 1'b0; wdt_tmo = 1'b0; brk_det = 1'b0; bod_det = 1'b0;
      step(3);
      check($sformatf("R4/R7-R10 vector %0d flags", v), reg_rdata, {2'b00, e[21:16]});
      check($sformatf("R11 vector %0d chip_rst", v), {7'd0, chip_rst}, {7'd0, e[23]});
      step(12);
    end

    // R12 asynchronous latency (break)
    brk_rst_en = 1'b1;
    wr_stat(8'h00);
    brk_det = 1'b1;
    step(1);
    brk_det = 1'b0;
    check("R12 break after edge 1", reg_rdata, 8'h00);
    step(1);
    check("R12 break after edge 2", reg_rdata, 8'h00);
    step(1);
    check("R12 break after edge 3", reg_rdata, 8'h08);

    // R4 accumulation
    sw_rst_req = 1'b1;
    step(1);
    sw_rst_req = 1'b0;
    check("R4 flags accumulate", reg_rdata, 8'h0A);

    // R5 and R1 write semantics
    wr_stat(8'hFF);
    check("R5 write ones no effect", reg_rdata, 8'h0A);
    wr_stat(8'hF7);
    check("R5 clear only zero bit", reg_rdata, 8'h02);
    wr_stat(8'hC0);
    check("R1 reserved bits read zero", reg_rdata, 8'h00);

    // R6 set beats clear
    reg_wr = 1'b1; reg_wdata = 8'h00; sw_rst_req = 1'b1;
    step(1);
    reg_wr = 1'b0; sw_rst_req = 1'b0;
    check("R6 set wins", reg_rdata, 8'h02);

    // R2 second power-on clears other flags
    step(12);
    brk_det = 1'b1;
    step(4);
    brk_det = 1'b0;
    por_n = 1'b0;
    step(1);
    check("R2 power-on status", reg_rdata, 8'h30);
    check("R2 power-on chip_rst", {7'd0, chip_rst}, 8'h01);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule